// File: doc/BRIEF.md
# Channel Interrupt Status Aggregator

This block gathers the period-done events of three audio DMA channels into one status word: two playback channels and one capture channel. Each channel owns one pending bit. An event sets its pending bit only when the channel's interrupt-enable bit in the serial-control register is on. A summary bit in the status word reports whether any pending bit is set. A level-sensitive interrupt line follows the pending bits one cycle later.

Software cannot write the status word. The only way to clear a pending bit is to turn off the matching enable bit. On every serial-control write, the surrounding register logic presents both the previous and the new register value. The block keeps its own copy of the three enable bits, updated from each write, and uses it to gate events. The channel counters and the host-bus decode sit outside this block.

Top module: `chan_irq_status`

## Requirements
- R1: A period-done event on input lane 2 (playback one) sets status bit 2. Lane 1 (playback two) sets bit 1. Lane 0 (capture) sets bit 0. The new bit is visible on the status port from the cycle after the clock edge that samples the event.
- R2: Status bit 31 is 1 exactly when at least one of status bits 0 to 2 is 1, in every cycle.
- R3: The interrupt line is registered. After each clock edge it equals the OR of status bits 0 to 2 as they stood before that edge.
- R4: An event sets its pending bit only if the stored enable is 1. Serial-control bit 8 enables playback one, bit 9 playback two and bit 10 capture. A write changes the stored enables from the next cycle on, so an event in the same cycle as the write is gated by the earlier enables.
- R5: A write whose old value has an enable bit at 1 and whose new value has it at 0 clears the matching pending bit.
- R6: While reset is high, the status word reads 0x00000060 and the interrupt line is low. The stored enables reset to 0.
- R7: Status bits 3 to 30 never change from their reset pattern.
- R8: When a clear (R5) and a set (R4) hit the same pending bit in the same cycle, the bit ends up 0.
- R9: A write that leaves an enable at 1 or raises it from 0 to 1 leaves pending bits unchanged. A set pending bit stays set through idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_done | input | 3 | Period-done pulses; lane 2 playback one, lane 1 playback two, lane 0 capture |
| sctl_wr | input | 1 | Serial-control write strobe |
| sctl_old | input | 32 | Serial-control value before the write |
| sctl_new | input | 32 | Serial-control value being written |
| stat_word | output | 32 | Status word for reads |
| irq | output | 1 | Level interrupt, one cycle behind the pending bits |

## Verification
Events are first sent with every enable off, to show that gating works. Then one enable at a time is turned on, to show that each event lane lands in its own status bit. A write that enables and an event arrive in the same cycle, to separate the old enables from the new ones. The writes used include ones that keep an enable high, ones that drop a single enable, and ones that drop an enable while its event fires; these separate a true falling-edge clear from a level-based clear and from a set-wins priority. Idle cycles after the bits are set and after they are cleared show the one-cycle lag of the interrupt line and the summary bit following the pending bits.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
  localparam int CH_CNT     = 3;
  localparam int REG_W      = 32;
  localparam int EN_LSB_DEF = 8;

  // enable position for status lane i: the highest lane maps to the lowest enable
  function automatic int en_pos(input int lsb, input int nch, input int lane);
    return lsb + nch - 1 - lane;
  endfunction
endpackage

// File: rtl/cis_enable_reg.sv
module cis_enable_reg #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [NCH-1:0] en_new,
  output logic [NCH-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst)     en_q <= '0;
    else if (wr) en_q <= en_new;
  end
endmodule

// File: rtl/cis_pend_cell.sv
module cis_pend_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_q
);
  always_ff @(posedge clk) begin
    if (rst)        pend_q <= 1'b0;
    else if (clr_i) pend_q <= 1'b0;   // clear has priority over set
    else if (set_i) pend_q <= 1'b1;
  end
endmodule

// File: rtl/cis_irq_reg.sv
module cis_irq_reg #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pend,
  output logic           irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pend;
  end
endmodule

// File: rtl/chan_irq_status.sv
module chan_irq_status
  import chan_irq_pkg::*;
#(
  parameter int NCH    = CH_CNT,
  parameter int SCTL_W = REG_W,
  parameter int STAT_W = REG_W,
  parameter int EN_LSB = EN_LSB_DEF,
  parameter logic [STAT_W-1:0] STAT_RST = 32'h0000_0060
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    evt_done,
  input  logic              sctl_wr,
  input  logic [SCTL_W-1:0] sctl_old,
  input  logic [SCTL_W-1:0] sctl_new,
  output logic [STAT_W-1:0] stat_word,
  output logic              irq
);
  localparam int SUM_BIT = STAT_W - 1;
  localparam int FIX_W   = STAT_W - 1 - NCH;

  logic [NCH-1:0] en_new_lane, en_old_lane, en_q, set_v, clr_v, pend;
  logic           sctl_unused;

  assign sctl_unused = ^{sctl_old, sctl_new};

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    localparam int EB = en_pos(EN_LSB, NCH, i);
    assign en_new_lane[i] = sctl_new[EB];
    assign en_old_lane[i] = sctl_old[EB];
    assign clr_v[i] = sctl_wr & en_old_lane[i] & ~en_new_lane[i];
    assign set_v[i] = evt_done[i] & en_q[i];

    cis_pend_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .set_i (set_v[i]),
      .clr_i (clr_v[i]),
      .pend_q(pend[i])
    );
  end

  cis_enable_reg #(.NCH(NCH)) u_en (
    .clk   (clk),
    .rst   (rst),
    .wr    (sctl_wr),
    .en_new(en_new_lane),
    .en_q  (en_q)
  );

  cis_irq_reg #(.NCH(NCH)) u_irq (
    .clk  (clk),
    .rst  (rst),
    .pend (pend),
    .irq_q(irq)
  );

  logic [FIX_W-1:0] fixed_bits;
  assign fixed_bits = STAT_RST[SUM_BIT-1:NCH];
  assign stat_word  = {|pend, fixed_bits, pend};
endmodule

// File: rtl/chan_irq_status_chk.sv
module chan_irq_status_chk #(
  parameter int NCH    = 3,
  parameter int SCTL_W = 32,
  parameter int STAT_W = 32,
  parameter int EN_LSB = 8,
  parameter logic [STAT_W-1:0] STAT_RST = 32'h0000_0060
) (
  input logic              clk,
  input logic              rst,
  input logic [NCH-1:0]    evt_done,
  input logic              sctl_wr,
  input logic [SCTL_W-1:0] sctl_old,
  input logic [SCTL_W-1:0] sctl_new,
  input logic [STAT_W-1:0] stat_word,
  input logic              irq
);
  AST_SUMMARY_MATCH: assert property (@(posedge clk) disable iff (rst)
    stat_word[STAT_W-1] == (|stat_word[NCH-1:0])); // R2

  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (rst)
    (|stat_word[NCH-1:0]) |=> irq); // R3

  AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (rst)
    !(|stat_word[NCH-1:0]) |=> !irq); // R3

  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
    stat_word[STAT_W-2:NCH] == STAT_RST[STAT_W-2:NCH]); // R7

  AST_RESET_VALUE: assert property (@(posedge clk)
    rst |=> (stat_word == STAT_RST && !irq)); // R6

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    localparam int EB = EN_LSB + NCH - 1 - i;
    AST_CLEAR_ON_FALL: assert property (@(posedge clk) disable iff (rst)
      (sctl_wr && sctl_old[EB] && !sctl_new[EB]) |=> !stat_word[i]); // R5
    AST_SET_NEEDS_EVT: assert property (@(posedge clk) disable iff (rst)
      $rose(stat_word[i]) |-> $past(evt_done[i])); // R4
  end
endmodule

bind chan_irq_status chan_irq_status_chk #(
  .NCH(NCH), .SCTL_W(SCTL_W), .STAT_W(STAT_W), .EN_LSB(EN_LSB), .STAT_RST(STAT_RST)
) u_chk (
  .clk(clk), .rst(rst), .evt_done(evt_done), .sctl_wr(sctl_wr),
  .sctl_old(sctl_old), .sctl_new(sctl_new), .stat_word(stat_word), .irq(irq)
);

// File: tb/chan_irq_status_bench.sv
module chan_irq_status_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  evt_done = '0;
  logic        sctl_wr = 1'b0;
  logic [31:0] sctl_old = '0;
  logic [31:0] sctl_new = '0;
  logic [31:0] stat_word;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;

  typedef struct {
    logic [31:0] st;
    logic        irq;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  // requirement model state
  logic [2:0] m_pend = '0;
  logic [2:0] m_en   = '0;

  always #5 clk = ~clk;

  chan_irq_status u_chan_irq_status (
    .clk(clk), .rst(rst), .evt_done(evt_done), .sctl_wr(sctl_wr),
    .sctl_old(sctl_old), .sctl_new(sctl_new), .stat_word(stat_word), .irq(irq)
  );

  function automatic logic [31:0] mk_status(input logic [2:0] p);
    return {|p, 28'h000000C, p};
  endfunction

  // driver: presents one cycle of stimulus and queues the predicted result
  task automatic step(input logic [2:0] ev, input logic wr,
                      input logic [31:0] o, input logic [31:0] n, input string tag);
    logic [2:0] clr, set, nxt, ol, nl;
    exp_t e;
    @(negedge clk);
    evt_done = ev; sctl_wr = wr; sctl_old = o; sctl_new = n;
    ol = {o[8], o[9], o[10]};
    nl = {n[8], n[9], n[10]};
    clr = wr ? (ol & ~nl) : 3'b000;
    set = ev & m_en;
    nxt = (m_pend & ~clr) | (set & ~clr);
    e.irq = |m_pend;
    e.st  = mk_status(nxt);
    e.tag = tag;
    sb_q.push_back(e);
    m_pend = nxt;
    if (wr) m_en = nl;
  endtask

  // monitor: compares after each clock edge, well before the next negedge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        vectors++;
        if (stat_word !== e.st || irq !== e.irq) begin
          miscompares++;
          $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                   e.tag, stat_word, irq, e.st, e.irq);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    vectors++;
    if (stat_word !== 32'h60 || irq !== 1'b0) begin
      miscompares++;
      $display("FAIL R6 reset: status=%h irq=%b expected status=00000060 irq=0", stat_word, irq);
    end
    @(negedge clk); rst = 1'b0;
    step(3'b000, 0, 32'h0, 32'h0, "R6 idle after reset");
    step(3'b111, 0, 32'h0, 32'h0, "R4 events with enables off");
    step(3'b000, 1, 32'h0, 32'h100, "R4 enable playback one");
    step(3'b111, 0, 32'h0, 32'h0, "R1 R4 only lane 2 sets");
    step(3'b000, 0, 32'h0, 32'h0, "R3 irq follows, R7 R2");
    step(3'b001, 1, 32'h100, 32'h700, "R4 same-cycle enable uses old");
    step(3'b001, 0, 32'h0, 32'h0, "R1 capture sets bit 0");
    step(3'b010, 0, 32'h0, 32'h0, "R1 playback two sets bit 1");
    step(3'b000, 1, 32'h700, 32'h700, "R9 steady enable keeps bits");
    step(3'b000, 0, 32'h0, 32'h0, "R9 idle keeps bits");
    step(3'b000, 1, 32'h700, 32'h300, "R5 capture enable falls");
    step(3'b100, 1, 32'h300, 32'h200, "R8 clear beats set");
    step(3'b000, 1, 32'h200, 32'h000, "R5 R2 last bit cleared");
    step(3'b000, 0, 32'h0, 32'h0, "R3 irq drops");
    step(3'b111, 0, 32'h0, 32'h0, "R4 all disabled again");
    step(3'b000, 1, 32'h000, 32'h400, "R9 rising enable no clear");
    step(3'b001, 0, 32'h0, 32'h0, "R1 capture after re-enable");
    step(3'b000, 0, 32'h0, 32'h0, "R3 R2 final");
    @(posedge clk); #3;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule